// File: doc/BRIEF.md
# Fractional-Divider PWM Timebase

This block is the shared time reference for a group of PWM channels. A fractional divider turns the source clock into count-enable ticks. The divisor has an integer part and eight fraction bits, so the average tick period can be a non-integer number of source clocks. Each tick advances an up-counter whose width is chosen at run time. The counter wraps at the top of its range, and on that wrap the block gives a one-clock overflow pulse that channels use to start a new PWM period.

Software drives a single configuration write port. The divisor and resolution fields go into shadow registers and reach the active datapath only when a write also sets the self-clearing update bit. The pause and hold bits take effect directly. A three-state machine sequences the timer. In HELD, the counter and divider are forced to zero. In PAUSED, both are frozen. In RUN, the divider accumulates and the counter advances on each tick. The transitions are as follows. The hold bit sends any state to HELD. Clearing hold leaves HELD for RUN, or for PAUSED if pause is set. Setting pause moves RUN to PAUSED, and clearing pause moves PAUSED back to RUN.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the count output is 0, the overflow output is 0, and the timer stays held until a write clears the hold bit.
- R2: While the hold bit (write data bit 24) is 1, the count reads 0 and no overflow pulse occurs.
- R3: With an integer divisor N (fraction bits 0), the count advances exactly once every N source clocks while running.
- R4: With divisor D (18 bits, low 8 bits fractional), after m running clocks the number of ticks is floor(256·m / D).
- R5: The counter wraps from 2^res − 1 to 0. Overflow is high for exactly the one clock in which the count shows that 0.
- R6: While the pause bit (write data bit 23) is 1, the count holds its value. Clearing pause resumes counting.
- R7: The write data carries resolution in bits 4:0, divisor in bits 22:5 and update in bit 25. Resolution and divisor written without the update bit have no effect on counting. With the update bit set, both are applied one clock after the write, the count and accumulator restart from 0, and the update request clears itself.
- R8: A divisor whose integer part is 0 is treated as integer part 1 with the same fraction, so a divisor of 0 ticks every clock.
- R9: A resolution of 0 is treated as 1 (count toggles 0,1). Values above the counter width are clamped to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_data_i | input | 26 | Configuration word: res[4:0], div[22:5], pause[23], hold[24], update[25] |
| count_o | output | 20 | Current timer count |
| ovf_o | output | 1 | One-clock pulse when the count wraps to 0 |

## Verification
The bench sweeps integer divisors 1 to 4 against resolutions 0 to 3, and compares count and overflow on every clock with the arithmetic tick count. A counter that wrapped one step late, or that pulsed overflow on the wrong clock, would fail at the first wrap. Fractional divisors of 2.5, 1.75 and 1.5 test that the accumulator carries its remainder; a divider that truncated the fraction would drift away from floor(256·m/D) within a few periods. The bench also checks that a zero divisor does not stall, that divisor writes without the update bit are ignored, and that pause freezes and hold zeroes the count, so a design that applied shadow values early or kept counting when paused would show a wrong count at the ports.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
    typedef enum logic [1:0] {
        ST_HELD   = 2'd0,
        ST_PAUSED = 2'd1,
        ST_RUN    = 2'd2
    } tb_state_t;
endpackage

// File: rtl/ptb_fracdiv.sv
module ptb_fracdiv #(
    parameter int DIV_W  = 18,
    parameter int FRAC_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             clr_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    localparam int INT_W = DIV_W - FRAC_W;

    logic [DIV_W-1:0] acc_q;
    logic [DIV_W:0]   eff;
    logic [DIV_W:0]   sum;

    // integer part 0 is promoted to 1, fraction kept (R8)
    always_comb begin
        if (div_i[DIV_W-1:FRAC_W] == '0)
            eff = {1'b0, INT_W'(1), div_i[FRAC_W-1:0]};
        else
            eff = {1'b0, div_i};
        sum    = {1'b0, acc_q} + (DIV_W+1)'(1 << FRAC_W);
        tick_o = en_i && (sum >= eff);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            acc_q <= '0;
        else if (clr_i)
            acc_q <= '0;
        else if (en_i)
            acc_q <= tick_o ? DIV_W'(sum - eff) : DIV_W'(sum);
    end

    // remainder always below the effective divisor (R4)
    p_acc_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ({1'b0, acc_q} < eff));

    // accumulator frozen when not running (R6)
    p_acc_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i && !clr_i) |=> $stable(acc_q));
endmodule

// File: rtl/ptb_counter.sv
module ptb_counter #(
    parameter int CNT_W = 20,
    parameter int RES_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic [RES_W-1:0] res_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);
    logic [CNT_W-1:0] top_w;

    assign top_w = {CNT_W{1'b1}} >> (RES_W'(CNT_W) - res_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_o <= '0;
            ovf_o <= 1'b0;
        end else if (clr_i) begin
            cnt_o <= '0;
            ovf_o <= 1'b0;
        end else if (tick_i) begin
            if (cnt_o == top_w) begin
                cnt_o <= '0;
                ovf_o <= 1'b1;
            end else begin
                cnt_o <= cnt_o + 1'b1;
                ovf_o <= 1'b0;
            end
        end else begin
            ovf_o <= 1'b0;
        end
    end

    p_ovf_at_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |-> (cnt_o == '0));

    p_ovf_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |=> !ovf_o);

    p_cnt_in_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_o <= top_w);
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import ptb_pkg::*;
#(
    parameter int CNT_W  = 20,
    parameter int RES_W  = 5,
    parameter int DIV_W  = 18,
    parameter int FRAC_W = 8,
    parameter int CFG_W  = RES_W + DIV_W + 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [CFG_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o
);
    localparam int DIV_LO  = RES_W;
    localparam int PAUSE_B = RES_W + DIV_W;
    localparam int HOLD_B  = PAUSE_B + 1;
    localparam int UPD_B   = PAUSE_B + 2;
    localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(1 << FRAC_W);
    localparam logic [RES_W-1:0] RES_MAX = RES_W'(CNT_W);

    logic [RES_W-1:0] res_sh, res_act, res_eff;
    logic [DIV_W-1:0] div_sh, div_act;
    logic             pause_q, hold_q, upd_q;
    tb_state_t        state_q, state_d;
    logic             run_en, clr, tick;

    // write port: shadow fields, direct control bits, self-clearing update
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            res_sh  <= RES_W'(1);
            div_sh  <= DIV_RST;
            pause_q <= 1'b0;
            hold_q  <= 1'b1;
            upd_q   <= 1'b0;
        end else if (wr_en_i) begin
            res_sh  <= wr_data_i[RES_W-1:0];
            div_sh  <= wr_data_i[DIV_LO+DIV_W-1:DIV_LO];
            pause_q <= wr_data_i[PAUSE_B];
            hold_q  <= wr_data_i[HOLD_B];
            upd_q   <= wr_data_i[UPD_B];
        end else begin
            upd_q   <= 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            res_act <= RES_W'(1);
            div_act <= DIV_RST;
        end else if (upd_q) begin
            res_act <= res_sh;
            div_act <= div_sh;
        end
    end

    always_comb begin
        if (res_act == '0)
            res_eff = RES_W'(1);
        else if (res_act > RES_MAX)
            res_eff = RES_MAX;
        else
            res_eff = res_act;
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_HELD;
        else         state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HELD: begin
                if (!hold_q) state_d = pause_q ? ST_PAUSED : ST_RUN;
            end
            ST_PAUSED: begin
                if (hold_q)        state_d = ST_HELD;
                else if (!pause_q) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (hold_q)       state_d = ST_HELD;
                else if (pause_q) state_d = ST_PAUSED;
            end
            default: state_d = ST_HELD;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        run_en = 1'b0;
        clr    = upd_q;
        unique case (state_q)
            ST_HELD:   clr    = 1'b1;
            ST_PAUSED: run_en = 1'b0;
            ST_RUN:    run_en = 1'b1;
            default:   clr    = 1'b1;
        endcase
    end

    ptb_fracdiv #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (run_en),
        .clr_i  (clr),
        .div_i  (div_act),
        .tick_o (tick)
    );

    ptb_counter #(.CNT_W(CNT_W), .RES_W(RES_W)) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (clr),
        .tick_i (tick),
        .res_i  (res_eff),
        .cnt_o  (count_o),
        .ovf_o  (ovf_o)
    );

    p_hold_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_HELD) |=> (count_o == '0) && !ovf_o);

    p_pause_freeze_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_PAUSED) |=> $stable(count_o));

    p_upd_selfclr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upd_q && !wr_en_i) |=> !upd_q);

    p_upd_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_q |=> (count_o == '0));
endmodule

// File: tb/pwm_timebase_bench.sv
`timescale 1ns/1ps
module pwm_timebase_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [25:0] wr_data = '0;
    logic [19:0] count;
    logic        ovf;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    pwm_timebase u_pwm_timebase (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .count_o   (count),
        .ovf_o     (ovf)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int res, input int div, input bit pau,
                      input bit hld, input bit upd);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = {upd, hld, pau, 18'(div), 5'(res)};
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    function automatic int eff_div(input int div);
        return ((div >> 8) == 0) ? (256 + (div & 255)) : div;
    endfunction

    function automatic int ticks(input int div, input int m);
        return (256 * m) / eff_div(div);
    endfunction

    // load div/res while held, release, then compare every clock
    task automatic run_seq(input int div, input int res, input int cyc,
                           input string tag);
        int rr;
        int span;
        wr(res, div, 1'b0, 1'b1, 1'b1);
        repeat (2) @(posedge clk);
        wr(res, div, 1'b0, 1'b0, 1'b0);
        rr   = (res == 0) ? 1 : res;
        span = 1 << rr;
        @(posedge clk);
        for (int m = 1; m <= cyc; m++) begin
            int t, tp;
            @(posedge clk);
            @(negedge clk);
            t  = ticks(div, m);
            tp = ticks(div, m - 1);
            check({tag, " count"}, int'(count), t % span);
            check("R5 ovf", int'(ovf), ((t != tp) && (t % span == 0)) ? 1 : 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 count", int'(count), 0);
        check("R1 ovf", int'(ovf), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 held count", int'(count), 0);

        // R3 and R9: integer divisors against small resolutions
        for (int n = 1; n <= 4; n++)
            for (int r = 0; r <= 3; r++)
                run_seq(n << 8, r, 24, (r == 0) ? "R9" : "R3");

        // R4 fractional divisors
        run_seq(32'h280, 4, 40, "R4");
        run_seq(32'h1C0, 3, 40, "R4");
        // R8 integer part zero
        run_seq(0, 5, 20, "R8");
        run_seq(32'h080, 3, 30, "R8");

        // R7 shadow without update has no effect: active stays 2
        run_seq(2 << 8, 4, 4, "R7");
        wr(4, 3 << 8, 1'b0, 1'b1, 1'b0);
        repeat (2) @(posedge clk);
        wr(4, 3 << 8, 1'b0, 1'b0, 1'b0);
        @(posedge clk);
        for (int m = 1; m <= 20; m++) begin
            @(posedge clk);
            @(negedge clk);
            check("R7 no-update count", int'(count), (m / 2) % 16);
        end
        // R7 with update: restart at 0, new divisor 3
        wr(4, 3 << 8, 1'b0, 1'b0, 1'b1);
        @(posedge clk);
        for (int m = 1; m <= 20; m++) begin
            @(posedge clk);
            @(negedge clk);
            check("R7 update count", int'(count), (m / 3) % 16);
        end

        // R6 pause freezes, resume continues
        run_seq(1 << 8, 6, 5, "R6");
        wr(6, 1 << 8, 1'b1, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        begin
            int snap;
            int moved;
            snap  = int'(count);
            moved = 0;
            repeat (20) begin
                @(negedge clk);
                if (int'(count) != snap) moved = 1;
            end
            check("R6 frozen", moved, 0);
            wr(6, 1 << 8, 1'b0, 1'b0, 1'b0);
            repeat (4) @(negedge clk);
            check("R6 resumed", (int'(count) != snap) ? 1 : 0, 1);
        end

        // R2 hold forces zero
        wr(6, 1 << 8, 1'b0, 1'b1, 1'b0);
        repeat (2) @(negedge clk);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            check("R2 held count", int'(count), 0);
            check("R2 held ovf", int'(ovf), 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule